// File: doc/BRIEF.md
# Inter-Processor Command Frame Checker

This block sits where a 32-bit word stream arrives from a neighbouring processor's outbound queue. Every request on that stream starts with a channel word, then a header word, then a payload whose length the header encodes. The checker splits each request into these three parts. It forwards the payload words downstream, each tagged with its channel, and pulses a per-channel strobe once a request has fully arrived. It also records which channels hold a request that has not yet been answered. When the response for a channel goes out, a completion pulse for that channel releases it again.

Three faults stop the block: a channel word outside the supported set, a header that asks for too many payload words, and a new request on a channel that is still busy. Each fault sets a sticky flag and an error code, and the input is held off until software issues a synchronous clear. Channels are independent of each other. A busy channel only refuses a second request of its own, and requests on other channels keep flowing. The highest channel number is a placeholder: its frames are consumed and then discarded.

Both streams use valid/ready handshakes. A word moves when valid and ready are high in the same clock cycle. The input is always ready for channel and header words, unless an error is pending. During the payload, input ready follows the downstream ready, so back-pressure passes straight through with no storage in between. The output valid only rises while an input word is offered. Payloads on the placeholder channel are absorbed whatever the downstream ready does.

Top module: `ipc_frame_checker`

## Requirements
- R1: A frame is one channel word, one header word, then N payload words. N is header bits [5:0] plus header bits [11:6]. The word accepted after the last payload word (or after the header when N is 0) is read as the channel word of a new frame.
- R2: Each payload word on channels 0 to 8 appears on `m_data` with `m_valid` high and `m_ch` equal to the channel, together with its input word. `m_last` is high on the final word. During the payload, `s_ready` equals `m_ready`. The output valid is low while channel and header words are being accepted.
- R3: `req_strobe` has exactly the bit of the frame's channel high, for one cycle, in the cycle after the frame's final word is accepted. Otherwise it is zero.
- R4: A channel's `busy` bit goes high in the cycle after its header word is accepted. It goes low in the cycle after that channel's `done` bit is pulsed.
- R5: A channel word with a value of 10 or more sets `err_flag` and sets `err_code` to 1.
- R6: A header with N greater than 63 sets `err_flag` with `err_code` 2, and `busy` is not set. N equal to 63 is accepted.
- R7: A channel word whose channel is busy sets `err_flag` with `err_code` 3. If that channel's `done` bit is high in the same cycle as the channel word, the word is not a duplicate.
- R8: Once set, `err_flag` and `err_code` hold and `s_ready` stays low until `err_clear` is pulsed. After the clear, `err_code` is 0 and the next accepted word is a channel word. The first fault's code is the one kept.
- R9: Frames on channel 9 are fully consumed. They produce no `m_valid`, no `req_strobe` bit and no `busy` bit.
- R10: A busy channel does not stall frames on other channels. A `done` pulse on one channel in the same cycle as another channel's header sets the new bit and clears the old one.
- R11: After reset, `s_ready` is 1, and `busy`, `req_strobe`, `err_flag` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input word offered |
| s_ready | output | 1 | Checker takes the input word |
| s_data | input | 32 | Input word |
| m_valid | output | 1 | Payload word offered downstream |
| m_ready | input | 1 | Downstream takes the payload word |
| m_data | output | 32 | Payload word |
| m_ch | output | 4 | Channel of the payload word |
| m_last | output | 1 | Final payload word of the frame |
| done | input | 10 | Per-channel completion pulse (response sent) |
| busy | output | 10 | Per-channel outstanding-request state |
| req_strobe | output | 10 | Per-channel request-complete pulse |
| err_clear | input | 1 | Synchronous clear of the error state |
| err_flag | output | 1 | Sticky fault flag |
| err_code | output | 2 | 0 none, 1 channel range, 2 oversize, 3 duplicate |

## Verification
Two functions can meet in one cycle. A completion pulse can arrive in the same cycle as a channel word for the same channel, and it can arrive in the same cycle as a header word for a different channel. The bench holds `done` high during the exact cycle in which such a word is accepted. For the same channel it expects no duplicate fault, followed by a fresh busy bit. For a different channel it expects one busy bit to be set and the other cleared in the same cycle. Random frames with random downstream back-pressure are mixed in, and their payload and strobe outputs are compared with a channel-busy model kept in the bench.

// File: rtl/ipc_chk_pkg.sv
package ipc_chk_pkg;
  typedef enum logic [1:0] {
    PS_CHAN = 2'd0,
    PS_HEAD = 2'd1,
    PS_BODY = 2'd2
  } pstate_t;

  typedef enum logic [1:0] {
    EC_NONE  = 2'd0,
    EC_RANGE = 2'd1,
    EC_SIZE  = 2'd2,
    EC_DUP   = 2'd3
  } ecode_t;
endpackage

// File: rtl/ipc_busy_track.sv
module ipc_busy_track #(
  parameter int NUM_CH  = 10,
  parameter int STUB_CH = 9,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [CH_W-1:0]   set_ch,
  input  logic [NUM_CH-1:0] done,
  output logic [NUM_CH-1:0] busy
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == STUB_CH) begin : g_stub
      assign busy[i] = 1'b0;
    end else begin : g_live
      logic b_q;
      always_ff @(posedge clk) begin
        if (!rst_n) b_q <= 1'b0;
        else if (set_en && set_ch == CH_W'(i)) b_q <= 1'b1;
        else if (done[i]) b_q <= 1'b0;
      end
      assign busy[i] = b_q;
    end
  end

  // R4
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> busy[$past(set_ch)]);

  // R7
  set_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (!busy[set_ch] || done[set_ch]));

  // R9
  stub_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (set_ch != CH_W'(STUB_CH)));
endmodule

// File: rtl/ipc_frame_parser.sv
module ipc_frame_parser
  import ipc_chk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 10,
  parameter int STUB_CH   = 9,
  parameter int FLD_W     = 6,
  parameter int MAX_FRAME = 64,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int LEN_W    = FLD_W + 1,
  localparam int MAX_PAY  = MAX_FRAME - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [CH_W-1:0]   m_ch,
  output logic              m_last,
  input  logic [NUM_CH-1:0] busy_now,
  output logic              set_en,
  output logic [CH_W-1:0]   set_ch,
  output logic [NUM_CH-1:0] req_strobe,
  input  logic              err_clear,
  output logic              err_flag,
  output logic [1:0]        err_code
);
  pstate_t           st_q;
  logic [CH_W-1:0]   ch_q;
  logic              stub_q;
  logic [LEN_W-1:0]  left_q;
  ecode_t            code_q;
  logic              acc, id_bad, id_dup, len_bad;
  logic [LEN_W-1:0]  hdr_len;

  always_comb begin
    s_ready = !err_flag && (st_q != PS_BODY || stub_q || m_ready);
    acc     = s_valid && s_ready;
    id_bad  = s_data >= DATA_W'(NUM_CH);
    id_dup  = !id_bad && busy_now[s_data[CH_W-1:0]];
    hdr_len = LEN_W'(s_data[FLD_W-1:0]) + LEN_W'(s_data[2*FLD_W-1:FLD_W]);
    len_bad = hdr_len > LEN_W'(MAX_PAY);
    set_en  = acc && st_q == PS_HEAD && !len_bad && !stub_q;
    set_ch  = ch_q;
    m_valid = s_valid && st_q == PS_BODY && !stub_q && !err_flag;
    m_data  = s_data;
    m_ch    = ch_q;
    m_last  = left_q == LEN_W'(1);
  end

  assign err_code = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= PS_CHAN;
      ch_q       <= '0;
      stub_q     <= 1'b0;
      left_q     <= '0;
      err_flag   <= 1'b0;
      code_q     <= EC_NONE;
      req_strobe <= '0;
    end else begin
      req_strobe <= '0;
      if (err_clear) begin
        err_flag <= 1'b0;
        code_q   <= EC_NONE;
        st_q     <= PS_CHAN;
      end else if (acc) begin
        unique case (st_q)
          PS_CHAN: begin
            if (id_bad) begin
              err_flag <= 1'b1;
              code_q   <= EC_RANGE;
            end else if (id_dup) begin
              err_flag <= 1'b1;
              code_q   <= EC_DUP;
            end else begin
              ch_q   <= s_data[CH_W-1:0];
              stub_q <= s_data[CH_W-1:0] == CH_W'(STUB_CH);
              st_q   <= PS_HEAD;
            end
          end
          PS_HEAD: begin
            if (len_bad) begin
              err_flag <= 1'b1;
              code_q   <= EC_SIZE;
            end else if (hdr_len == '0) begin
              st_q <= PS_CHAN;
              if (!stub_q) req_strobe <= NUM_CH'(1) << ch_q;
            end else begin
              left_q <= hdr_len;
              st_q   <= PS_BODY;
            end
          end
          default: begin
            left_q <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) begin
              st_q <= PS_CHAN;
              if (!stub_q) req_strobe <= NUM_CH'(1) << ch_q;
            end
          end
        endcase
      end
    end
  end

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> (err_flag && $stable(code_q)));

  // R8
  err_code_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (code_q != EC_NONE));

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_strobe));

  // R9
  stub_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_ch != CH_W'(STUB_CH)));
endmodule

// File: rtl/ipc_frame_checker.sv
module ipc_frame_checker #(
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 10,
  parameter int STUB_CH   = 9,
  parameter int FLD_W     = 6,
  parameter int MAX_FRAME = 64,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [CH_W-1:0]   m_ch,
  output logic              m_last,
  input  logic [NUM_CH-1:0] done,
  output logic [NUM_CH-1:0] busy,
  output logic [NUM_CH-1:0] req_strobe,
  input  logic              err_clear,
  output logic              err_flag,
  output logic [1:0]        err_code
);
  logic            set_en;
  logic [CH_W-1:0] set_ch;
  logic [NUM_CH-1:0] busy_now;

  // a completion in the same cycle releases the channel for the duplicate test
  assign busy_now = busy & ~done;

  ipc_frame_parser #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .STUB_CH(STUB_CH),
    .FLD_W(FLD_W), .MAX_FRAME(MAX_FRAME)
  ) u_parse (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_ch(m_ch), .m_last(m_last),
    .busy_now(busy_now), .set_en(set_en), .set_ch(set_ch),
    .req_strobe(req_strobe),
    .err_clear(err_clear), .err_flag(err_flag), .err_code(err_code)
  );

  ipc_busy_track #(.NUM_CH(NUM_CH), .STUB_CH(STUB_CH)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_ch(set_ch), .done(done), .busy(busy)
  );

  // R2
  bp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (s_ready == m_ready));
endmodule

// File: tb/sim_ipc_frame_checker.sv
`timescale 1ns/1ps
module sim_ipc_frame_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [31:0] m_data;
  logic [3:0]  m_ch;
  logic        m_last;
  logic [9:0]  done = '0;
  logic [9:0]  busy;
  logic [9:0]  req_strobe;
  logic        err_clear = 1'b0;
  logic        err_flag;
  logic [1:0]  err_code;

  int total = 0;
  int bad = 0;
  logic [9:0] mbusy = '0;
  bit bp_on = 1'b0;

  always #2.5 clk = ~clk;

  ipc_frame_checker u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_ch(m_ch), .m_last(m_last), .done(done), .busy(busy),
    .req_strobe(req_strobe), .err_clear(err_clear), .err_flag(err_flag),
    .err_code(err_code)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(input int n1, input int n2);
    return 32'((n2 << 6) | n1) | (32'($urandom) & 32'hFFFF_F000);
  endfunction

  // called at a negedge; returns at the negedge after the accepting edge
  // mode: 0 no output check, 1 expect payload out, 2 expect no output
  task automatic put(input logic [31:0] w, input int mode, input int ch, input bit last);
    bit rdy;
    s_valid = 1'b1;
    s_data  = w;
    forever begin
      m_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
      #1;
      rdy = s_ready;
      if (mode == 1) begin
        chk(m_valid == 1'b1, "R2 m_valid", m_valid, 1);
        chk(m_data == w, "R2 m_data", m_data, w);
        chk(m_ch == 4'(ch), "R2 m_ch", m_ch, ch);
        chk(m_last == last, "R2 m_last", m_last, last);
        chk(s_ready == m_ready, "R2 backpressure", s_ready, m_ready);
      end else if (mode == 2) begin
        chk(m_valid == 1'b0 && s_ready == 1'b1, "R9 stub no output", {m_valid, s_ready}, 1);
      end else begin
        chk(m_valid == 1'b0, "R2 no output on id/header", m_valid, 0);
      end
      @(negedge clk);
      if (rdy) break;
    end
    s_valid = 1'b0;
    m_ready = 1'b1;
  endtask

  task automatic frame(input int ch, input int n1, input int n2);
    int n = n1 + n2;
    put(32'(ch), 0, ch, 0);
    put(mk_hdr(n1, n2), 0, ch, 0);
    if (ch != 9) mbusy[ch] = 1'b1;
    if (n == 0) begin
      chk(req_strobe == ((ch != 9) ? (10'd1 << ch) : 10'd0), "R3 strobe (empty)", req_strobe, (ch != 9) ? (10'd1 << ch) : 0);
    end else begin
      chk(busy == mbusy, "R4 busy after header", busy, mbusy);
      for (int i = 0; i < n; i++) put($urandom, (ch == 9) ? 2 : 1, ch, i == n - 1);
      chk(req_strobe == ((ch != 9) ? (10'd1 << ch) : 10'd0), "R3 strobe", req_strobe, (ch != 9) ? (10'd1 << ch) : 0);
    end
    @(negedge clk);
    chk(req_strobe == 10'd0, "R3 strobe single cycle", req_strobe, 0);
    chk(busy == mbusy, "R4 busy model", busy, mbusy);
  endtask

  task automatic complete(input int ch);
    done = 10'd1 << ch;
    @(negedge clk);
    done = '0;
    mbusy[ch] = 1'b0;
    chk(busy == mbusy, "R4 busy cleared by done", busy, mbusy);
  endtask

  task automatic expect_err(input int code, input string req);
    chk(err_flag == 1'b1 && err_code == 2'(code), req, {err_flag, err_code}, {1'b1, 2'(code)});
    chk(s_ready == 1'b0, "R8 ready low in error", s_ready, 0);
    s_valid = 1'b1;
    s_data  = 32'd2;
    repeat (2) @(negedge clk);
    chk(s_ready == 1'b0 && err_flag && err_code == 2'(code), "R8 sticky", {s_ready, err_flag, err_code}, {1'b0, 1'b1, 2'(code)});
    s_valid = 1'b0;
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    chk(err_flag == 1'b0 && err_code == 2'd0 && s_ready, "R8 clear", {err_flag, err_code, s_ready}, 3'b001);
    chk(busy == mbusy, "R8 busy kept across error", busy, mbusy);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11
    chk(s_ready && busy == 0 && req_strobe == 0 && !err_flag && err_code == 0,
        "R11 reset state", {s_ready, busy, req_strobe, err_flag, err_code}, {1'b1, 22'd0});
    @(negedge clk);

    // R1 basic frames, including empty payload
    frame(0, 2, 1);
    frame(1, 0, 0);
    frame(2, 0, 3);
    // R10: channel 0,1,2 busy; channel 3 still runs
    frame(3, 1, 0);
    // R6 boundary 63 accepted
    frame(5, 32, 31);
    // R9 stub channel
    frame(9, 2, 2);
    frame(9, 0, 0);

    // R5 range fault
    put(32'd10, 0, 0, 0);
    expect_err(1, "R5 range error code");
    put(32'hFFFF_FFFF, 0, 0, 0);
    expect_err(1, "R5 range error large id");

    // R6 oversize
    put(32'd6, 0, 6, 0);
    put(mk_hdr(40, 30), 0, 6, 0);
    expect_err(2, "R6 oversize code");
    chk(busy[6] == 1'b0, "R6 busy not set", busy[6], 0);
    put(32'd7, 0, 7, 0);
    put(mk_hdr(63, 1), 0, 7, 0);
    expect_err(2, "R6 oversize 64");

    // R7 duplicate
    put(32'd3, 0, 3, 0);
    expect_err(3, "R7 duplicate code");

    // R7 done in same cycle as the channel word: not a duplicate
    done = 10'd1 << 4;
    complete(0);
    frame(4, 1, 1);
    done = 10'd1 << 4;
    put(32'd4, 0, 4, 0);
    done = '0;
    mbusy[4] = 1'b0;
    chk(!err_flag, "R7 done same cycle no dup", err_flag, 0);
    put(mk_hdr(0, 0), 0, 4, 0);
    mbusy[4] = 1'b1;
    chk(req_strobe == 10'd1 << 4 && busy == mbusy, "R7 re-armed", busy, mbusy);
    @(negedge clk);

    // R10 done on channel 1 in the same cycle as channel 6 header
    put(32'd6, 0, 6, 0);
    done = 10'd1 << 1;
    put(mk_hdr(1, 0), 0, 6, 0);
    done = '0;
    mbusy[1] = 1'b0;
    mbusy[6] = 1'b1;
    chk(busy == mbusy, "R10 set and clear same cycle", busy, mbusy);
    put(32'hA5A5_0001, 1, 6, 1);
    chk(req_strobe == 10'd1 << 6, "R3 strobe ch6", req_strobe, 10'd1 << 6);
    @(negedge clk);

    // random frames with back-pressure
    bp_on = 1'b1;
    for (int k = 0; k < 60; k++) begin
      int ch = int'($urandom % 10);
      if (ch != 9 && mbusy[ch]) complete(ch);
      frame(ch, int'($urandom % 6), int'($urandom % 4));
      if (($urandom % 2) == 1) begin
        int c2 = int'($urandom % 9);
        if (mbusy[c2]) complete(c2);
      end
    end
    // R1: stream still aligned, a fresh frame parses
    bp_on = 1'b0;
    for (int c = 0; c < 9; c++) if (mbusy[c]) complete(c);
    frame(8, 3, 0);
    chk(!err_flag, "R1 alignment after random run", err_flag, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule